// File: doc/BRIEF.md
# Quad PWM Group with Paired and Center-Aligned Modes

This block produces four pulse-width modulated lines from one shared period counter. The lines form two pairs. In paired mode the second line of each pair is the inverse of the first, and one duty value sets both lines. In non-paired mode each of the four lines compares the counter against its own duty value. The counter runs in one of two shapes. In edge-aligned operation it ramps up and wraps. In center-aligned operation it ramps up and then back down, so pulses sit around the period boundary.

Software writes configuration through a small write port into shadow copies. Shadow values become active only at update points. The mode and the period are taken at every period start. Duty values are taken at every period start and, when double update is selected in center-aligned operation, also at the turnaround in mid-period. This lets the two halves of a pulse differ in width. A one-cycle sync output marks the first cycle of every period. While the enable is low, all outputs stay low and the active registers follow the shadows.

Top module: `pwm_quad_group`

## Requirements
- R1: After reset all four PWM lines and the sync output are low.
- R2: In edge-aligned mode (mode bit 0 = 0) the counter runs 0..P-1 and wraps. Sync is high exactly when the count is 0, once every P cycles. A line is high in the first D cycles of each period, where D is its duty and P its period.
- R3: In center-aligned mode (mode bit 0 = 1) a period lasts 2P cycles. The count runs 0..P-1 upward, then P-1..0 downward. A line is high while the count is below D, so it is high for 2D cycles, placed symmetrically in time. Sync marks the first upward 0.
- R4: A duty of 0 keeps a line low. A duty at or above the period keeps it high.
- R5: In paired mode (mode bit 1 = 1), line 1 is the inverse of line 0 and line 3 is the inverse of line 2. Only duty 0 (address 2) and duty 2 (address 4) are used; the writes to addresses 3 and 5 have no effect on the lines.
- R6: In non-paired mode, line k follows duty k, written at address 2+k, independently of the other lines.
- R7: A duty write while running does not change the lines before the next update point.
- R8: With double update (mode bit 2 = 1) in center-aligned mode, duty values are also loaded when the count turns at P-1. The downward half then uses the newly written duty.
- R9: Without double update in center-aligned mode, a duty written during the upward half takes effect only at the next period start.
- R10: The period (address 1) and the mode (address 0) change only at a period start.
- R11: While the enable is low, all lines and sync are low. The first enabled cycle is a period start that already uses the values written while disabled.
- R12: A period value of 0 acts as a period of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (3) | Write address: 0 mode, 1 period, 2+k duty k |
| wr_data_i | input | CNT_W (16) | Write data; for the mode register, bit 0 selects center alignment, bit 1 selects paired mode, bit 2 selects double update |
| pwm_o | output | NUM_OUT (4) | PWM lines |
| sync_o | output | 1 | High in the first cycle of each period |

## Verification
The first stimulus runs edge-aligned, non-paired, with duties of zero, mid-range, just below the period and above it. This separates the per-line compare from the two saturation cases. A paired run uses distinct odd duties, so a line that wrongly follows its own duty shows up against the inverse of its partner. Center-aligned runs record a whole period and compare the upward and downward halves. A duty is then rewritten in mid-period with double update on and off, which separates a midpoint load from a start-only load. Further runs cover a period rewritten mid-period, dropping and restoring the enable, and a zero period.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;
  // write data bit 0 center, bit 1 paired, bit 2 double update
  typedef struct packed {
    logic dbl_upd;
    logic paired;
    logic center;
  } mode_t;

  localparam int unsigned ADDR_MODE   = 0;
  localparam int unsigned ADDR_PERIOD = 1;
  localparam int unsigned ADDR_DUTY0  = 2;
endpackage

// File: rtl/pwm_grp_regs.sv
module pwm_grp_regs
  import pwm_grp_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [CNT_W-1:0]                 wr_data_i,
  input  logic                             load_all_i,
  input  logic                             load_mid_i,
  output mode_t                            mode_o,
  output logic [CNT_W-1:0]                 period_o,
  output logic [NUM_OUT-1:0][CNT_W-1:0]    duty_o
);

  mode_t                          mode_sh, mode_act_q;
  logic [CNT_W-1:0]               per_sh, per_act_q;
  logic [NUM_OUT-1:0][CNT_W-1:0]  duty_sh, duty_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_sh <= '0;
      per_sh  <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(ADDR_MODE))   mode_sh <= mode_t'(wr_data_i[2:0]);
      if (wr_addr_i == ADDR_W'(ADDR_PERIOD)) per_sh  <= wr_data_i;
    end
  end

  // mode and period: period start only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_act_q <= '0;
      per_act_q  <= '0;
    end else if (load_all_i) begin
      mode_act_q <= mode_sh;
      per_act_q  <= per_sh;
    end
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_duty
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        duty_sh[k] <= '0;
      end else if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_DUTY0 + k)) begin
        duty_sh[k] <= wr_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        duty_act_q[k] <= '0;
      end else if (load_all_i || load_mid_i) begin
        duty_act_q[k] <= duty_sh[k];
      end
    end
  end

  assign mode_o   = mode_act_q;
  assign period_o = per_act_q;
  assign duty_o   = duty_act_q;

  p_period_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_all_i |=> $stable(per_act_q));

  p_mode_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_all_i |=> $stable(mode_act_q));

endmodule

// File: rtl/pwm_grp_timebase.sv
module pwm_grp_timebase
  import pwm_grp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  mode_t            mode_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_all_o,
  output logic             load_mid_o,
  output logic             sync_o
);

  logic [CNT_W-1:0] cnt_q, per_eff, last;
  logic             down_q;
  logic             wrap, turn;

  assign per_eff = (period_i == '0) ? CNT_W'(1) : period_i;
  assign last    = per_eff - CNT_W'(1);

  always_comb begin
    if (mode_i.center) wrap = down_q && (cnt_q == '0);
    else               wrap = (cnt_q == last);
    turn       = mode_i.center && !down_q && (cnt_q == last);
    load_all_o = !en_i || wrap;
    load_mid_o = en_i && turn && mode_i.dbl_upd;
    sync_o     = en_i && !down_q && (cnt_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (!en_i || wrap) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (turn) begin
      down_q <= 1'b1;
    end else if (down_q) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < per_eff));

endmodule

// File: rtl/pwm_grp_outs.sv
module pwm_grp_outs
  import pwm_grp_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned NUM_PAIRS = 2,
  localparam int unsigned NUM_OUT  = 2 * NUM_PAIRS
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  mode_t                         mode_i,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [NUM_OUT-1:0][CNT_W-1:0] duty_i,
  output logic [NUM_OUT-1:0]            pwm_o
);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic hi_a, hi_b;
    assign hi_a = cnt_i < duty_i[2*p];
    assign hi_b = cnt_i < duty_i[2*p+1];
    assign pwm_o[2*p]   = en_i && hi_a;
    assign pwm_o[2*p+1] = en_i && (mode_i.paired ? !hi_a : hi_b);

    p_pair_compl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && mode_i.paired) |-> (pwm_o[2*p+1] != pwm_o[2*p]));
  end

  p_dis_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (pwm_o == '0));

endmodule

// File: rtl/pwm_quad_group.sv
module pwm_quad_group
  import pwm_grp_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned NUM_PAIRS = 2,
  localparam int unsigned NUM_OUT  = 2 * NUM_PAIRS,
  localparam int unsigned ADDR_W   = $clog2(NUM_OUT + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  output logic [NUM_OUT-1:0] pwm_o,
  output logic               sync_o
);

  mode_t                         mode;
  logic [CNT_W-1:0]              period, cnt;
  logic [NUM_OUT-1:0][CNT_W-1:0] duty;
  logic                          load_all, load_mid;

  pwm_grp_regs #(
    .CNT_W  (CNT_W),
    .NUM_OUT(NUM_OUT),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .load_all_i(load_all),
    .load_mid_i(load_mid),
    .mode_o    (mode),
    .period_o  (period),
    .duty_o    (duty)
  );

  pwm_grp_timebase #(
    .CNT_W(CNT_W)
  ) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .mode_i    (mode),
    .period_i  (period),
    .cnt_o     (cnt),
    .load_all_o(load_all),
    .load_mid_o(load_mid),
    .sync_o    (sync_o)
  );

  pwm_grp_outs #(
    .CNT_W    (CNT_W),
    .NUM_PAIRS(NUM_PAIRS)
  ) u_outs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .mode_i(mode),
    .cnt_i (cnt),
    .duty_i(duty),
    .pwm_o (pwm_o)
  );

endmodule

// File: tb/pwm_quad_group_test.sv
module pwm_quad_group_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [3:0]  pwm_o;
  logic        sync_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] h_pwm [0:63];
  logic       h_sync [0:63];

  always #4 clk_i = ~clk_i;

  pwm_quad_group uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .pwm_o    (pwm_o),
    .sync_o   (sync_o)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wr_en_i   = 1'b1;
    wr_addr_i = 3'(addr);
    wr_data_i = 16'(data);
    @(posedge clk_i); #3;
    wr_en_i   = 1'b0;
  endtask

  task automatic setup(input int mode, input int per, input int d0, input int d1,
                       input int d2, input int d3);
    en_i = 1'b0;
    @(posedge clk_i); #3;
    wr(0, mode); wr(1, per);
    wr(2, d0); wr(3, d1); wr(4, d2); wr(5, d3);
    @(posedge clk_i); #3;
  endtask

  task automatic start();
    en_i = 1'b1;
    #1;
  endtask

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      h_pwm[i]  = pwm_o;
      h_sync[i] = sync_o;
      @(posedge clk_i); #3;
    end
  endtask

  function automatic int hi_cnt(input int k, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (h_pwm[i][k]) c++;
    return c;
  endfunction

  function automatic int sync_cnt(input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (h_sync[i]) c++;
    return c;
  endfunction

  task automatic t_reset();
    chk("R1 pwm after reset", int'(pwm_o), 0);
    chk("R1 sync after reset", int'(sync_o), 0);
  endtask

  task automatic t_edge();
    setup(0, 10, 3, 7, 0, 15);
    start();
    capture(20);
    chk("R2 line0 high cycles", hi_cnt(0, 20), 6);
    chk("R6 line1 own duty", hi_cnt(1, 20), 14);
    chk("R4 duty zero low", hi_cnt(2, 20), 0);
    chk("R4 duty over period high", hi_cnt(3, 20), 20);
    chk("R2 sync count", sync_cnt(20), 2);
    chk("R2 sync at count 0", int'(h_sync[0]) + int'(h_sync[10]), 2);
    chk("R2 line0 leads period", int'(h_pwm[0][0]) * 2 + int'(h_pwm[3][0]), 2);
  endtask

  task automatic t_paired();
    int mism = 0;
    setup(2, 8, 4, 1, 6, 3);
    start();
    capture(8);
    for (int i = 0; i < 8; i++)
      if (h_pwm[i][1] == h_pwm[i][0] || h_pwm[i][3] == h_pwm[i][2]) mism++;
    chk("R5 complement mismatches", mism, 0);
    chk("R5 line0", hi_cnt(0, 8), 4);
    chk("R5 line1 ignores own duty", hi_cnt(1, 8), 4);
    chk("R5 line2", hi_cnt(2, 8), 6);
    chk("R5 line3 ignores own duty", hi_cnt(3, 8), 2);
  endtask

  task automatic t_center();
    int asym = 0;
    setup(1, 6, 2, 6, 0, 0);
    start();
    capture(24);
    for (int i = 0; i < 12; i++) if (h_pwm[i][0] != h_pwm[11-i][0]) asym++;
    chk("R3 symmetry mismatches", asym, 0);
    chk("R3 high cycles 2D", hi_cnt(0, 24), 8);
    chk("R3 high at start", int'(h_pwm[0][0]), 1);
    chk("R3 low at turn", int'(h_pwm[5][0]) + int'(h_pwm[6][0]), 0);
    chk("R3 sync every 2P", sync_cnt(24), 2);
    chk("R3 sync position", int'(h_sync[12]), 1);
    chk("R4 duty equals period", hi_cnt(1, 24), 24);
  endtask

  task automatic t_shadow();
    setup(0, 10, 3, 0, 0, 0);
    start();
    capture(3);
    chk("R7 old duty first cycles", hi_cnt(0, 3), 3);
    wr(2, 7);
    capture(6);
    chk("R7 no change mid period", hi_cnt(0, 6), 0);
    capture(10);
    chk("R7 new duty next period", hi_cnt(0, 10), 7);
  endtask

  task automatic t_center_upd(input bit dbl);
    setup(dbl ? 5 : 1, 8, 2, 0, 0, 0);
    start();
    capture(5);
    wr(2, 5);
    capture(2);
    chk(dbl ? "R8 upper rise" : "R9 upper rise", hi_cnt(0, 2), 0);
    capture(8);
    if (dbl) chk("R8 down half new duty", hi_cnt(0, 8), 5);
    else     chk("R9 down half old duty", hi_cnt(0, 8), 2);
    capture(8);
    chk(dbl ? "R8 next up half" : "R9 next up half", hi_cnt(0, 8), 5);
  endtask

  task automatic t_period();
    setup(0, 10, 0, 0, 0, 0);
    start();
    capture(2);
    wr(1, 4);
    capture(8);
    chk("R10 old period kept", sync_cnt(8), 1);
    chk("R10 sync at cycle 10", int'(h_sync[7]), 1);
    capture(8);
    chk("R10 new period used", sync_cnt(8), 2);
  endtask

  task automatic t_enable();
    setup(2, 8, 3, 0, 5, 0);
    start();
    capture(4);
    en_i = 1'b0;
    #1;
    chk("R11 lines low when off", int'(pwm_o), 0);
    chk("R11 sync low when off", int'(sync_o), 0);
    @(posedge clk_i); #3;
    wr(2, 6);
    @(posedge clk_i); #3;
    en_i = 1'b1;
    #1;
    chk("R11 sync on restart", int'(sync_o), 1);
    capture(8);
    chk("R11 new duty at restart", hi_cnt(0, 8), 6);
    chk("R11 partner inverse", hi_cnt(1, 8), 2);
  endtask

  task automatic t_zero_period();
    setup(0, 0, 1, 0, 0, 0);
    start();
    capture(5);
    chk("R12 sync each cycle", sync_cnt(5), 5);
    chk("R12 duty 1 fills period", hi_cnt(0, 5), 5);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #3;
    t_reset();
    rst_ni = 1'b1;
    @(posedge clk_i); #3;
    t_edge();
    t_paired();
    t_center();
    t_shadow();
    t_center_upd(1'b1);
    t_center_upd(1'b0);
    t_period();
    t_enable();
    t_zero_period();
    report();
    $finish;
  end

endmodule